// File: doc/BRIEF.md
# Security Attribution and Access Checker

This block sits next to a processor's instruction-fetch and data ports and judges every address it is shown. It first works out the address's security attribute: Non-secure (NS), Non-secure-callable (NSC) or Secure (S). Two sources feed this result. One is a fixed map whose ranges and attributes are set by parameters. The other is a programmable table of regions, and any address that no enabled region covers counts as Secure. The stricter of the two results becomes the final attribute.

The block then applies the access rules for the current security state and access kind, and answers with either a grant or a security fault. The answer is registered and appears one cycle after the request.

A small write port loads the region table. Only writes marked as secure change it. A write without that mark leaves the table untouched and raises a one-cycle reject flag.

Top module: `sec_access_checker`

## Requirements
- R1: The attribute encoding is NS=0, NSC=1, S=2, ordered from least to most restrictive. `rsp_attr` is the more restrictive of the fixed-map result and the table result.
- R2: With default parameters the fixed map marks the ranges as follows:
  - 0x0000_0000 to 0x0FFF_FFFF: NS
  - 0x1000_0000 to 0x1FFF_FFFF: S
  - 0x2000_0000 to 0x2FFF_FFFF: NS
  - 0x3000_0000 to 0x3FFF_FFFF: NSC

  An address outside every fixed range imposes no restriction, so the fixed map reports NS for it.
- R3: The table holds 8 regions. Each region has a base and a limit, both on a 32-byte granule, and the limit granule is included in the region. Each region also has an enable bit and an NSC bit. An enabled region that covers an address yields NSC when its NSC bit is 1, and NS otherwise.
- R4: An address that no enabled region covers gets S from the table.
- R5: Where enabled regions overlap, NSC wins over NS.
- R6: A data access made in secure state is granted for every attribute.
- R7: A data access made in non-secure state is granted only when the attribute is NS.
- R8: A fetch made in secure state is granted for S and NSC, and faults for NS.
- R9: A fetch made in non-secure state behaves as follows:
  - NS: granted.
  - NSC: granted only when `req_is_gateway` is 1.
  - S: faults.
- R10: A request with `req_valid` high produces, one cycle later, `rsp_valid` together with exactly one of `rsp_grant` and `rsp_fault`. Without a request, both stay low.
- R11: `cfg_wr_sel` chooses what a write updates:
  - 0: base (data bits 31:5).
  - 1: limit (data bits 31:5).
  - 2: control (data bit 0 = enable, bit 1 = NSC).
  - 3: nothing.

  A secure write takes effect for requests in later cycles. A non-secure write changes nothing and pulses `cfg_wr_reject` in the next cycle.
- R12: After synchronous reset, every region is disabled and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | 32 | Address to classify |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_nonsec | input | 1 | 1 = processor currently in non-secure state |
| req_is_gateway | input | 1 | Fetched opcode is the secure-gateway instruction |
| cfg_wr_en | input | 1 | Region register write strobe |
| cfg_wr_secure | input | 1 | The write is issued from secure state |
| cfg_wr_idx | input | 3 | Region number |
| cfg_wr_sel | input | 2 | Field select (base, limit, control) |
| cfg_wr_data | input | 32 | Write data |
| cfg_wr_reject | output | 1 | Pulse for an ignored non-secure write |
| rsp_valid | output | 1 | Result of last cycle's request |
| rsp_attr | output | 2 | Final attribute |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Security fault |

## Verification
The assertions assume that `req_fetch`, `req_nonsec` and `req_is_gateway` are steady for the whole cycle in which `req_valid` is sampled, because the checker reads them back through `$past`. They also assume that `cfg_wr_idx` never names a region beyond the table. The bench drives every input on the falling edge and keeps to region numbers 0 to 7. Its random phase aims addresses at the fixed-map ranges, at the programmed windows and at unmapped space, and mixes secure and non-secure writes into the same cycles as requests. This last point exercises the rule that a write only affects later lookups.

// File: rtl/sac_pkg.sv
package sac_pkg;
  typedef enum logic [1:0] {
    ATTR_NS  = 2'd0,
    ATTR_NSC = 2'd1,
    ATTR_S   = 2'd2
  } attr_t;

  localparam logic [1:0] SEL_BASE  = 2'd0;
  localparam logic [1:0] SEL_LIMIT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  localparam int GRAN_BITS = 5;

  function automatic attr_t attr_max(attr_t a, attr_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sac_fixed_map.sv
module sac_fixed_map
  import sac_pkg::*;
#(
  parameter int AW = 32,
  parameter int NFIX = 4,
  parameter logic [NFIX*AW-1:0] FIX_LO = '0,
  parameter logic [NFIX*AW-1:0] FIX_HI = '0,
  parameter logic [NFIX*2-1:0]  FIX_ATTR = '0
) (
  input  logic [AW-1:0] addr,
  output attr_t         attr
);
  always_comb begin
    attr = ATTR_NS;
    for (int i = 0; i < NFIX; i++) begin
      if (addr >= FIX_LO[i*AW +: AW] && addr <= FIX_HI[i*AW +: AW])
        attr = attr_max(attr, attr_t'(FIX_ATTR[i*2 +: 2]));
    end
  end
endmodule

// File: rtl/sac_region_table.sv
module sac_region_table
  import sac_pkg::*;
#(
  parameter int AW = 32,
  parameter int NREG = 8,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int GW = AW - GRAN_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_secure,
  input  logic [IW-1:0] wr_idx,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  output logic          wr_reject,
  input  logic [AW-1:0] lk_addr,
  output attr_t         lk_attr
);
  logic [GW-1:0]   base_q  [NREG];
  logic [GW-1:0]   limit_q [NREG];
  logic [NREG-1:0] en_q;
  logic [NREG-1:0] nsc_q;
  logic [NREG-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_reject <= 1'b0;
      en_q      <= '0;
      nsc_q     <= '0;
      for (int i = 0; i < NREG; i++) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
      end
    end else begin
      wr_reject <= wr_en && !wr_secure;
      if (wr_en && wr_secure && (32'(wr_idx) < NREG)) begin
        case (wr_sel)
          SEL_BASE:  base_q[wr_idx]  <= wr_data[AW-1:GRAN_BITS];
          SEL_LIMIT: limit_q[wr_idx] <= wr_data[AW-1:GRAN_BITS];
          SEL_CTRL: begin
            en_q[wr_idx]  <= wr_data[0];
            nsc_q[wr_idx] <= wr_data[1];
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign hit[g] = en_q[g] &&
                    (lk_addr[AW-1:GRAN_BITS] >= base_q[g]) &&
                    (lk_addr[AW-1:GRAN_BITS] <= limit_q[g]);
  end

  always_comb begin
    if (hit == '0)             lk_attr = ATTR_S;
    else if ((hit & nsc_q) != '0) lk_attr = ATTR_NSC;
    else                       lk_attr = ATTR_NS;
  end
endmodule

// File: rtl/sac_policy.sv
module sac_policy
  import sac_pkg::*;
(
  input  attr_t attr,
  input  logic  fetch,
  input  logic  nonsec,
  input  logic  gateway,
  output logic  allow
);
  always_comb begin
    if (!fetch)
      allow = nonsec ? (attr == ATTR_NS) : 1'b1;
    else if (!nonsec)
      allow = (attr != ATTR_NS);
    else
      allow = (attr == ATTR_NS) || (attr == ATTR_NSC && gateway);
  end
endmodule

// File: rtl/sec_access_checker.sv
module sec_access_checker
  import sac_pkg::*;
#(
  parameter int AW = 32,
  parameter int NREG = 8,
  parameter int NFIX = 4,
  parameter logic [NFIX*AW-1:0] FIX_LO =
    {32'h3000_0000, 32'h2000_0000, 32'h1000_0000, 32'h0000_0000},
  parameter logic [NFIX*AW-1:0] FIX_HI =
    {32'h3FFF_FFFF, 32'h2FFF_FFFF, 32'h1FFF_FFFF, 32'h0FFF_FFFF},
  parameter logic [NFIX*2-1:0] FIX_ATTR = {2'd1, 2'd0, 2'd2, 2'd0},
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_fetch,
  input  logic          req_nonsec,
  input  logic          req_is_gateway,
  input  logic          cfg_wr_en,
  input  logic          cfg_wr_secure,
  input  logic [IW-1:0] cfg_wr_idx,
  input  logic [1:0]    cfg_wr_sel,
  input  logic [AW-1:0] cfg_wr_data,
  output logic          cfg_wr_reject,
  output logic          rsp_valid,
  output logic [1:0]    rsp_attr,
  output logic          rsp_grant,
  output logic          rsp_fault
);
  attr_t fix_attr, tab_attr, eff_attr;
  logic  allow;

  sac_fixed_map #(
    .AW(AW), .NFIX(NFIX), .FIX_LO(FIX_LO), .FIX_HI(FIX_HI), .FIX_ATTR(FIX_ATTR)
  ) u_fix (
    .addr(req_addr),
    .attr(fix_attr)
  );

  sac_region_table #(.AW(AW), .NREG(NREG)) u_tab (
    .clk(clk),
    .rst(rst),
    .wr_en(cfg_wr_en),
    .wr_secure(cfg_wr_secure),
    .wr_idx(cfg_wr_idx),
    .wr_sel(cfg_wr_sel),
    .wr_data(cfg_wr_data),
    .wr_reject(cfg_wr_reject),
    .lk_addr(req_addr),
    .lk_attr(tab_attr)
  );

  assign eff_attr = attr_max(fix_attr, tab_attr);

  sac_policy u_pol (
    .attr(eff_attr),
    .fetch(req_fetch),
    .nonsec(req_nonsec),
    .gateway(req_is_gateway),
    .allow(allow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_attr  <= 2'd0;
      rsp_grant <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_attr  <= eff_attr;
      rsp_grant <= req_valid && allow;
      rsp_fault <= req_valid && !allow;
    end
  end
endmodule

// File: rtl/sac_checker.sv
module sac_checker (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_fetch,
  input logic       req_nonsec,
  input logic       req_is_gateway,
  input logic       cfg_wr_en,
  input logic       cfg_wr_secure,
  input logic       cfg_wr_reject,
  input logic       rsp_valid,
  input logic [1:0] rsp_attr,
  input logic       rsp_grant,
  input logic       rsp_fault
);
  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_grant ^ rsp_fault));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_grant && !rsp_fault));

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_attr_code_R1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_attr != 2'b11));

  assert_sec_data_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(req_nonsec) && !$past(req_fetch)) |-> rsp_grant);

  assert_ns_data_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_grant && $past(req_nonsec) && !$past(req_fetch)) |-> (rsp_attr == 2'd0));

  assert_sec_fetch_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_grant && !$past(req_nonsec) && $past(req_fetch)) |-> (rsp_attr != 2'd0));

  assert_ns_fetch_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_grant && $past(req_nonsec) && $past(req_fetch)) |->
      (rsp_attr == 2'd0 || (rsp_attr == 2'd1 && $past(req_is_gateway))));

  assert_reject_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_en && !cfg_wr_secure) |=> cfg_wr_reject);

  assert_reject_cause_R11: assert property (@(posedge clk) disable iff (rst)
    cfg_wr_reject |-> $past(cfg_wr_en && !cfg_wr_secure));
endmodule

bind sec_access_checker sac_checker u_chk (
  .clk(clk),
  .rst(rst),
  .req_valid(req_valid),
  .req_fetch(req_fetch),
  .req_nonsec(req_nonsec),
  .req_is_gateway(req_is_gateway),
  .cfg_wr_en(cfg_wr_en),
  .cfg_wr_secure(cfg_wr_secure),
  .cfg_wr_reject(cfg_wr_reject),
  .rsp_valid(rsp_valid),
  .rsp_attr(rsp_attr),
  .rsp_grant(rsp_grant),
  .rsp_fault(rsp_fault)
);

// File: tb/tb_sec_access_checker.sv
`timescale 1ns/1ps
module tb_sec_access_checker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_fetch = 1'b0;
  logic        req_nonsec = 1'b0;
  logic        req_is_gateway = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_wr_secure = 1'b0;
  logic [2:0]  cfg_wr_idx = '0;
  logic [1:0]  cfg_wr_sel = '0;
  logic [31:0] cfg_wr_data = '0;
  logic        cfg_wr_reject;
  logic        rsp_valid;
  logic [1:0]  rsp_attr;
  logic        rsp_grant;
  logic        rsp_fault;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [26:0] mb [8];
  logic [26:0] ml [8];
  logic [7:0]  men = '0;
  logic [7:0]  mnsc = '0;

  always #2.5 clk = ~clk;

  sec_access_checker dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_fetch(req_fetch),
    .req_nonsec(req_nonsec), .req_is_gateway(req_is_gateway),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_secure(cfg_wr_secure),
    .cfg_wr_idx(cfg_wr_idx), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .cfg_wr_reject(cfg_wr_reject),
    .rsp_valid(rsp_valid), .rsp_attr(rsp_attr),
    .rsp_grant(rsp_grant), .rsp_fault(rsp_fault)
  );

  function automatic int fix_attr(logic [31:0] a);
    if (a <= 32'h0FFF_FFFF) return 0;
    if (a <= 32'h1FFF_FFFF) return 2;
    if (a <= 32'h2FFF_FFFF) return 0;
    if (a <= 32'h3FFF_FFFF) return 1;
    return 0;
  endfunction

  function automatic int tab_attr(logic [31:0] a);
    bit any_ns = 0;
    bit any_nsc = 0;
    for (int i = 0; i < 8; i++) begin
      if (men[i] && a[31:5] >= mb[i] && a[31:5] <= ml[i]) begin
        if (mnsc[i]) any_nsc = 1;
        else any_ns = 1;
      end
    end
    if (any_nsc) return 1;
    if (any_ns) return 0;
    return 2;
  endfunction

  function automatic bit allowed(int at, bit f, bit ns, bit gw);
    if (!f) return ns ? (at == 0) : 1'b1;
    if (!ns) return at != 0;
    return (at == 0) || (at == 1 && gw);
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic step(bit v, logic [31:0] a, bit f, bit ns, bit gw,
                      bit we, bit ws, int wi, int wsel, logic [31:0] wd, string tag);
    int fa, ta, ea;
    bit ok;
    req_valid = v; req_addr = a; req_fetch = f; req_nonsec = ns; req_is_gateway = gw;
    cfg_wr_en = we; cfg_wr_secure = ws; cfg_wr_idx = 3'(wi);
    cfg_wr_sel = 2'(wsel); cfg_wr_data = wd;
    fa = fix_attr(a);
    ta = tab_attr(a);
    ea = (fa > ta) ? fa : ta;
    ok = allowed(ea, f, ns, gw);
    if (we && ws) begin
      case (wsel)
        0: mb[wi] = wd[31:5];
        1: ml[wi] = wd[31:5];
        2: begin men[wi] = wd[0]; mnsc[wi] = wd[1]; end
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "rsp_valid", int'(rsp_valid), int'(v));
    check(tag, "rsp_grant", int'(rsp_grant), int'(v && ok));
    check(tag, "rsp_fault", int'(rsp_fault), int'(v && !ok));
    check(tag, "cfg_wr_reject", int'(cfg_wr_reject), int'(we && !ws));
    if (v) check(tag, "rsp_attr", int'(rsp_attr), ea);
  endtask

  task automatic acc(logic [31:0] a, bit f, bit ns, bit gw, string tag);
    step(1, a, f, ns, gw, 0, 0, 0, 0, 32'h0, tag);
  endtask

  task automatic wr(int idx, int sel, logic [31:0] d, bit sec, string tag);
    step(0, 32'h0, 0, 0, 0, 1, sec, idx, sel, d, tag);
  endtask

  task automatic region(int idx, logic [31:0] lo, logic [31:0] hi, bit nsc, string tag);
    wr(idx, 0, lo, 1, tag);
    wr(idx, 1, hi, 1, tag);
    wr(idx, 2, {30'h0, nsc, 1'b1}, 1, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mb[i] = '0; ml[i] = '0; end
    repeat (3) @(negedge clk);
    check("R12", "rsp_valid", int'(rsp_valid), 0);
    check("R12", "rsp_grant", int'(rsp_grant), 0);
    check("R12", "rsp_fault", int'(rsp_fault), 0);
    check("R12", "cfg_wr_reject", int'(cfg_wr_reject), 0);
    rst = 1'b0;

    // empty table: everything reads Secure (R4)
    acc(32'h0000_1000, 0, 0, 0, "R4");
    acc(32'h0000_1000, 0, 1, 0, "R7");
    acc(32'h8000_0040, 1, 0, 0, "R8");
    step(0, 32'h0000_1000, 0, 1, 0, 0, 0, 0, 0, 32'h0, "R10");

    // NS window, inclusive limit (R3)
    region(0, 32'h0000_1000, 32'h0000_1FE0, 0, "R3");
    acc(32'h0000_1000, 0, 1, 0, "R3");
    acc(32'h0000_1FFF, 0, 1, 0, "R3");
    acc(32'h0000_2000, 0, 1, 0, "R4");
    acc(32'h0000_0FFF, 0, 1, 0, "R4");

    // overlapping NSC window (R5, R9)
    region(1, 32'h0000_1800, 32'h0000_18E0, 1, "R5");
    acc(32'h0000_1810, 0, 0, 0, "R5");
    acc(32'h0000_1810, 1, 1, 0, "R9");
    acc(32'h0000_1810, 1, 1, 1, "R9");
    acc(32'h0000_1810, 1, 0, 0, "R8");
    acc(32'h0000_1810, 0, 1, 0, "R7");
    acc(32'h0000_1810, 0, 0, 0, "R6");

    // fixed map dominates (R1, R2)
    region(2, 32'h1000_0000, 32'h1000_0FE0, 0, "R2");
    acc(32'h1000_0100, 0, 1, 0, "R1");
    region(3, 32'h3000_0000, 32'h3000_0FE0, 0, "R2");
    acc(32'h3000_0020, 1, 1, 1, "R1");
    acc(32'h3000_0020, 1, 1, 0, "R9");
    region(4, 32'h8000_0000, 32'h8000_00E0, 0, "R2");
    acc(32'h8000_0060, 0, 1, 0, "R2");
    acc(32'h2000_0000, 0, 1, 0, "R2");

    // fetch rules on NS memory
    acc(32'h0000_1004, 1, 0, 0, "R8");
    acc(32'h0000_1004, 1, 1, 0, "R9");
    acc(32'h1000_0100, 1, 1, 1, "R9");
    acc(32'h1000_0100, 1, 0, 0, "R8");

    // non-secure write ignored, secure write applies (R11)
    wr(0, 2, 32'h0, 0, "R11");
    acc(32'h0000_1000, 0, 1, 0, "R11");
    wr(0, 3, 32'hFFFF_FFFF, 1, "R11");
    acc(32'h0000_1000, 0, 1, 0, "R11");
    step(1, 32'h0000_1000, 0, 1, 0, 1, 1, 0, 2, 32'h0, "R11");
    acc(32'h0000_1000, 0, 1, 0, "R11");

    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [31:0] bases [5];
      logic [31:0] a, d;
      int sel;
      bases[0] = 32'h0000_1000; bases[1] = 32'h1000_0000; bases[2] = 32'h2000_0000;
      bases[3] = 32'h3000_0000; bases[4] = 32'h8000_0000;
      a = bases[$urandom % 5] + ($urandom % 32'h2000);
      sel = $urandom % 4;
      d = (sel == 2) ? ($urandom % 4) : (bases[$urandom % 5] + ($urandom % 32'h2000));
      step(($urandom % 4) != 0, a, $urandom % 2, $urandom % 2, $urandom % 2,
           ($urandom % 3) == 0, ($urandom % 4) != 0, $urandom % 8, sel, d, "R10");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule